// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block is the master side of the two-wire station management bus used to reach registers inside Ethernet PHYs. It generates the management clock (MDC) from the system clock. It drives the bidirectional data line through a separate output-enable and samples the line when the PHY drives it. One request carries the complete access. The block returns a one-cycle completion pulse and, for reads, the 16-bit register value.

Two addressing styles are supported. A classic access sends one frame with a 5-bit register number. An extended access sends two frames back to back. The first is an address frame that loads a 16-bit register address into a 5-bit device inside the PHY. The second is the read or write frame for that device. On reads the block checks the bit that the PHY must pull low in the turnaround slot. If the PHY fails to do so, the block clocks the bus 32 more times to drain the PHY and reports all-ones.

The MDC period is two half-periods of `HALF_CYC` system clocks each. The high half must cover the PHY's output delay, including the latency of the input synchronizer.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no access is running, `mdc`, `mdio_oe`, `busy` and `done` are low, and `rdata` holds its last read result (0 after reset).
- R2: Every frame opens with 32 bit slots in which the master drives 1; the first slot begins in the cycle after the request is taken.
- R3: After the preamble the master drives 14 header bits in this order: a 2-bit start code, a 2-bit opcode, the 5-bit PHY address and the 5-bit register/device field, each field MSB first. Classic frames use start 01 and opcode 10 (read) or 01 (write). Extended frames use start 00 and opcode 00 (address), 11 (read) or 01 (write).
- R4: A write frame follows the header with driven turnaround bits 1 then 0, then 16 data bits MSB first, then one slot with the line released, and then completes.
- R5: A read frame releases the line right after the header and samples one turnaround slot. If that bit is 0, it samples 16 data bits MSB first, adds one released slot, completes, and returns the data on `rdata`. Writes leave `rdata` unchanged.
- R6: If the sampled read turnaround bit is 1, the master clocks 32 further released slots, ignoring their contents, completes with `rdata` = 16'hFFFF, and the read frame is 79 slots long.
- R7: With `req_c45` set, an address frame comes first, carrying `req_reg` as device field and `req_addr` as write-style data and ending with a released slot. The read or write frame for the same PHY and device follows it at once, with its own preamble.
- R8: Each bit slot lasts 2*HALF_CYC system clocks: `mdc` is low for the first HALF_CYC and high for the rest. `mdio_oe` and the driven data change only at slot starts.
- R9: `mdio_in` passes through a SYNC_STAGES-flop synchronizer and is captured in the last system clock of the MDC high phase. A PHY that changes the line one system clock after the MDC rising edge is therefore read correctly.
- R10: `busy` is high from the cycle after a request is taken until the cycle `done` pulses for one cycle, which is the cycle after the last slot. Requests presented while busy are ignored.
- R11: `mdio_oe` is high only in preamble, header, write turnaround and write data slots, and low in every slot the PHY may drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_c45 | input | 1 | 1 = extended (two-frame) access |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number (classic) or device number (extended) |
| req_addr | input | 16 | Register address for extended accesses |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Output-enable for the line driver |
| mdio_in | input | 1 | Line value as seen at the pin |

## Verification
The bench runs classic writes and reads, extended writes and reads, and reads where the PHY leaves the turnaround bit high. Together these separate the four opcodes, the two start codes, the write tail from the read tail, and the good-turnaround path from the flush path. In the flush case the PHY model drives zeros during the drain, so a design that keeps shifting data after a failed turnaround is caught. The PHY model changes the line only one system clock after each MDC rise, so sampling too early or forgetting the synchronizer delay returns the previous bit. One write receives conflicting requests while it runs, and its bit stream and completion time must stay unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int PRE_LEN   = 32;
   localparam int FLUSH_LEN = 32;
   localparam int FIELD_W   = 5;
   localparam int WORD_W    = 16;
   localparam int HDR_LEN   = 4 + 2 * FIELD_W;
   localparam int BCNT_W    = $clog2(PRE_LEN) + 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_HDR,
      ST_TAW,
      ST_WDAT,
      ST_RLS,
      ST_TAR,
      ST_RDAT,
      ST_FLUSH
   } seq_st_e;

   typedef struct packed {
      logic               wr;
      logic               c45;
      logic [FIELD_W-1:0] phy;
      logic [FIELD_W-1:0] regf;
      logic [WORD_W-1:0]  addr;
      logic [WORD_W-1:0]  wdata;
   } mdio_req_t;

   // start code, opcode, PHY field, register/device field
   function automatic logic [HDR_LEN-1:0] hdr_word(mdio_req_t r, logic addr_phase);
      logic [1:0] st;
      logic [1:0] op;
      st = r.c45 ? 2'b00 : 2'b01;
      if (r.c45)
         op = addr_phase ? 2'b00 : (r.wr ? 2'b01 : 2'b11);
      else
         op = r.wr ? 2'b01 : 2'b10;
      return {st, op, r.phy, r.regf};
   endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] ff;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) ff[i] <= 1'b1;
            else        ff[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) ff[i] <= 1'b1;
            else        ff[i] <= ff[i-1];
         end
      end
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/mdio_slot_timer.sv
module mdio_slot_timer #(
   parameter  int HALF_CYC = 18,
   localparam int CW       = $clog2(2 * HALF_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          mdc,
   output logic          slot_end,
   output logic [CW-1:0] phase
);

   localparam logic [CW-1:0] LAST = CW'(2 * HALF_CYC - 1);
   localparam logic [CW-1:0] HI   = CW'(HALF_CYC);

   logic [CW-1:0] phase_nxt;

   always_comb begin
      if (!run)               phase_nxt = '0;
      else if (phase == LAST) phase_nxt = '0;
      else                    phase_nxt = phase + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
         mdc   <= 1'b0;
      end else begin
         phase <= phase_nxt;
         mdc   <= (phase_nxt >= HI);
      end
   end

   assign slot_end = run && (phase == LAST);

   // MDC may only toggle at the slot start or the mid-slot point
   assert_mdc_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdc) |-> (phase == '0 || phase == HI));

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  mdio_req_t         req,
   input  logic              slot_end,
   input  logic              rx_bit,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rdata,
   output logic              tx_bit,
   output logic              tx_en,
   output seq_st_e           state
);

   mdio_req_t          req_q;
   logic               addr_ph;
   logic [BCNT_W-1:0]  bcnt;
   logic [HDR_LEN-1:0] hdr_sr;
   logic [WORD_W-1:0]  wd_sr;
   logic [WORD_W-1:0]  rd_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         req_q   <= '0;
         addr_ph <= 1'b0;
         bcnt    <= '0;
         hdr_sr  <= '0;
         wd_sr   <= '0;
         rd_sr   <= '0;
         rdata   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (req_valid) begin
               req_q   <= req;
               addr_ph <= req.c45;
               state   <= ST_PRE;
               bcnt    <= '0;
            end
         end else if (slot_end) begin
            bcnt <= bcnt + 1'b1;
            case (state)
               ST_PRE: begin
                  if (bcnt == BCNT_W'(PRE_LEN - 1)) begin
                     state  <= ST_HDR;
                     bcnt   <= '0;
                     hdr_sr <= hdr_word(req_q, addr_ph);
                  end
               end
               ST_HDR: begin
                  hdr_sr <= hdr_sr << 1;
                  if (bcnt == BCNT_W'(HDR_LEN - 1)) begin
                     bcnt <= '0;
                     if (req_q.wr || addr_ph) begin
                        state <= ST_TAW;
                        wd_sr <= addr_ph ? req_q.addr : req_q.wdata;
                     end else begin
                        state <= ST_TAR;
                     end
                  end
               end
               ST_TAW: begin
                  if (bcnt == BCNT_W'(1)) begin
                     state <= ST_WDAT;
                     bcnt  <= '0;
                  end
               end
               ST_WDAT: begin
                  wd_sr <= wd_sr << 1;
                  if (bcnt == BCNT_W'(WORD_W - 1)) begin
                     state <= ST_RLS;
                     bcnt  <= '0;
                  end
               end
               ST_TAR: begin
                  bcnt  <= '0;
                  state <= rx_bit ? ST_FLUSH : ST_RDAT;
               end
               ST_RDAT: begin
                  rd_sr <= {rd_sr[WORD_W-2:0], rx_bit};
                  if (bcnt == BCNT_W'(WORD_W - 1)) begin
                     state <= ST_RLS;
                     bcnt  <= '0;
                  end
               end
               ST_RLS: begin
                  bcnt <= '0;
                  if (addr_ph) begin
                     addr_ph <= 1'b0;
                     state   <= ST_PRE;
                  end else begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     if (!req_q.wr) rdata <= rd_sr;
                  end
               end
               ST_FLUSH: begin
                  if (bcnt == BCNT_W'(FLUSH_LEN - 1)) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                     rdata <= '1;
                     bcnt  <= '0;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy = (state != ST_IDLE);

   always_comb begin
      tx_bit = 1'b0;
      tx_en  = 1'b0;
      case (state)
         ST_PRE:  begin tx_en = 1'b1; tx_bit = 1'b1;              end
         ST_HDR:  begin tx_en = 1'b1; tx_bit = hdr_sr[HDR_LEN-1]; end
         ST_TAW:  begin tx_en = 1'b1; tx_bit = (bcnt == '0);      end
         ST_WDAT: begin tx_en = 1'b1; tx_bit = wd_sr[WORD_W-1];   end
         default: begin tx_en = 1'b0; tx_bit = 1'b0;              end
      endcase
   end

   // busy only starts from a presented request
   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // completion is a single-cycle pulse
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // captured request cannot change while an access runs
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(req_q));

   // a drained read always reports all-ones
   assert_flush_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(state) == ST_FLUSH) |-> (rdata == '1));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_CYC     = 18,
   parameter int SYNC_STAGES  = 2,
   parameter int CLK_NS       = 20,
   parameter int MIN_MDC_NS   = 400,
   parameter int PHY_DELAY_NS = 300
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic        req_c45,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_addr,
   input  logic [15:0] req_wdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rdata,
   output logic        mdc,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic        mdio_in
);

   localparam int CW = $clog2(2 * HALF_CYC);

   initial begin
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      assert (HALF_CYC >= SYNC_STAGES + 2)
         else $error("HALF_CYC too short for the synchronizer");
      assert (2 * HALF_CYC * CLK_NS >= MIN_MDC_NS)
         else $error("MDC period below the bus minimum");
      assert ((HALF_CYC - SYNC_STAGES) * CLK_NS >= PHY_DELAY_NS)
         else $error("MDC high phase does not cover PHY output delay");
   end

   mdio_req_t     req;
   logic          slot_end;
   logic          rx_bit;
   logic [CW-1:0] phase;
   seq_st_e       st;

   assign req = '{wr: req_write, c45: req_c45, phy: req_phy, regf: req_reg,
                  addr: req_addr, wdata: req_wdata};

   mdio_slot_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .slot_end (slot_end),
      .phase    (phase)
   );

   mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mdio_in),
      .q     (rx_bit)
   );

   mdio_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req       (req),
      .slot_end  (slot_end),
      .rx_bit    (rx_bit),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata),
      .tx_bit    (mdio_out),
      .tx_en     (mdio_oe),
      .state     (st)
   );

   // line direction changes only at a slot start, while MDC is low
   assert_oe_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> (phase == '0 && !mdc));

   // preamble slots are driven ones
   assert_pre_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE) |-> (mdio_oe && mdio_out));

   // the master never drives when the PHY may own the line
   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAR || st == ST_RDAT || st == ST_FLUSH || st == ST_RLS) |-> !mdio_oe);

   // nothing moves on the bus while idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

   localparam int H    = 18;
   localparam int SLOT = 2 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_c45 = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, mdc, mdio_out, mdio_oe;
   logic [15:0] rdata;
   logic        phy_pin = 1'b1;
   logic        mdio_in;

   always #10 clk = ~clk;

   assign mdio_in = mdio_oe ? mdio_out : phy_pin;

   mdio_master #(.HALF_CYC(H)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_c45(req_c45), .req_phy(req_phy), .req_reg(req_reg), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   int checks = 0;
   int fails  = 0;
   bit eo[$];
   bit ev[$];
   bit pv[$];
   logic [15:0] last_rd = '0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic put(bit o, bit v, bit p);
      eo.push_back(o);
      ev.push_back(v);
      pv.push_back(p);
   endtask

   task automatic frame(bit c45, bit [1:0] op, logic [4:0] phy, logic [4:0] rf);
      for (int i = 0; i < 32; i++) put(1, 1, 1);
      put(1, 0, 1);
      put(1, !c45, 1);
      put(1, op[1], 1);
      put(1, op[0], 1);
      for (int i = 4; i >= 0; i--) put(1, phy[i], 1);
      for (int i = 4; i >= 0; i--) put(1, rf[i], 1);
   endtask

   task automatic wtail(logic [15:0] w);
      put(1, 1, 1);
      put(1, 0, 1);
      for (int i = 15; i >= 0; i--) put(1, w[i], 1);
      put(0, 0, 1);
   endtask

   task automatic rtail(bit ok, logic [15:0] d);
      if (ok) begin
         put(0, 0, 0);
         for (int i = 15; i >= 0; i--) put(0, 0, d[i]);
         put(0, 0, 1);
      end else begin
         put(0, 0, 1);
         for (int i = 0; i < 32; i++) put(0, 0, 0);
      end
   endtask

   // one complete access against the behavioural slot model
   task automatic xfer(bit wr, bit c45, logic [4:0] phy, logic [4:0] rf, logic [15:0] addr,
                       logic [15:0] wd, bit ok, logic [15:0] rd, string tag, int inj,
                       int exp_slots);
      int n;
      eo.delete(); ev.delete(); pv.delete();
      if (c45) begin
         frame(1, 2'b00, phy, rf);
         wtail(addr);
      end
      if (wr) begin
         frame(c45, 2'b01, phy, rf);
         wtail(wd);
      end else begin
         frame(c45, c45 ? 2'b11 : 2'b10, phy, rf);
         rtail(ok, rd);
         last_rd = ok ? rd : 16'hFFFF;
      end
      n = eo.size();
      chk(n == exp_slots, tag, "model slot count", n, exp_slots);
      @(negedge clk);
      req_write = wr; req_c45 = c45; req_phy = phy; req_reg = rf;
      req_addr = addr; req_wdata = wd; req_valid = 1'b1;
      for (int k = 0; k <= n * SLOT + 1; k++) begin
         int s, p, idx;
         @(negedge clk);
         s = k / SLOT;
         p = k % SLOT;
         req_valid = (k == inj);
         if (k == inj) begin
            req_write = ~wr; req_c45 = ~c45; req_phy = ~phy; req_reg = ~rf;
         end
         idx = (p >= H + 1) ? s : s - 1;
         phy_pin = (idx >= 0 && idx < n) ? pv[idx] : 1'b1;
         if (k < n * SLOT) begin
            chk(mdc == (p >= H), "R8", "mdc", mdc, (p >= H));
            chk(mdio_oe == eo[s], "R11", "mdio_oe", mdio_oe, eo[s]);
            if (eo[s]) chk(mdio_out == ev[s], tag, "mdio_out", mdio_out, ev[s]);
            chk(busy == 1'b1, "R10", "busy during access", busy, 1);
            chk(done == 1'b0, "R10", "early done", done, 0);
         end else if (k == n * SLOT) begin
            chk(done == 1'b1, "R10", "done pulse", done, 1);
            chk(busy == 1'b0, "R10", "busy at done", busy, 0);
            chk(rdata == last_rd, tag, "rdata", rdata, last_rd);
            chk(!mdc && !mdio_oe, "R1", "bus quiet at done", {mdc, mdio_oe}, 0);
         end else begin
            chk(done == 1'b0, "R10", "done width", done, 0);
            chk(busy == 1'b0, "R1", "idle after access", busy, 0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mdc && !mdio_oe && !busy && !done, "R1", "idle outputs",
          {mdc, mdio_oe, busy, done}, 0);
      chk(rdata == 16'h0, "R1", "rdata reset", rdata, 0);
      // R2 R3 R4 classic write
      xfer(1, 0, 5'h13, 5'h0A, 16'h0, 16'hA5C3, 1, 16'h0, "R4", -1, 65);
      // R5 R9 classic read, valid turnaround
      xfer(0, 0, 5'h01, 5'h1F, 16'h0, 16'h0, 1, 16'h3C96, "R5", -1, 64);
      // R6 classic read, PHY absent
      xfer(0, 0, 5'h0C, 5'h02, 16'h0, 16'h0, 0, 16'h0, "R6", -1, 79);
      // R7 extended write
      xfer(1, 1, 5'h1E, 5'h07, 16'h8001, 16'h1234, 1, 16'h0, "R7", -1, 130);
      // R7 R5 extended read
      xfer(0, 1, 5'h05, 5'h03, 16'hFFFE, 16'h0, 1, 16'h8421, "R7", -1, 129);
      // R7 R6 extended read with failed turnaround
      xfer(0, 1, 5'h10, 5'h1D, 16'h00F0, 16'h0, 0, 16'h0, "R6", -1, 144);
      // R10 request injected mid-access must be ignored; R5 rdata kept across a write
      xfer(1, 0, 5'h0B, 5'h15, 16'h0, 16'h5A0F, 1, 16'h0, "R3", 700, 65);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule